// File: doc/BRIEF.md
# Shared Ready/Data Serial Output Port

This block drives a single output pin that works in two modes. In ready mode the pin signals that a new conversion result is available. In data mode the same pin carries that result as a serial bit stream, clocked by an external host. Each time a result-valid pulse arrives, the 24-bit result is captured into an output shift register during a transfer window. The pin then gives a LOW strobe followed by a HIGH strobe to announce the new data, and after that it enters data mode for a fixed window.

During the data window the host supplies serial clocks. Each falling serial clock edge moves the pin on to the next lower bit, so the host samples on the rising edge. Reads that stop early, reads that run past the end, and windows with no reads at all each leave the pin in a defined state until the window closes. When the window closes the pin returns to ready mode, and any bits not yet read are discarded. The serial clock is synchronised into the system clock domain and its falling edges are detected there. A result that arrives while the port is busy is kept in a holding register and is delivered next.

Top module: `rdy_dout_port`

## Requirements
- R1: After reset, and whenever no result is being delivered, the pin is HIGH.
- R2: After a result-valid pulse the pin stays HIGH for the transfer window (T_XFER cycles). It is then LOW for exactly T_LOW cycles, then HIGH for exactly T_HIGH cycles, and then data mode begins.
- R3: In data mode the pin first shows bit W-1 (the MSB). After the k-th detected falling edge of the serial clock it shows bit W-1-k.
- R4: If no serial clock falling edge arrives during data mode, the pin holds the MSB for the whole data window.
- R5: If fewer than W falling edges arrive, the pin holds the last bit shifted out until the data window ends.
- R6: Once W or more falling edges have arrived in data mode, the pin is LOW for the rest of the data window.
- R7: Data mode lasts T_DATA cycles, after which the pin returns HIGH. The next result always starts from its MSB, however much of the previous one was read.
- R8: A result that arrives while a previous one is still being delivered is held. It is announced and delivered in full after the current data window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, asynchronous to clk |
| res_vld | input | 1 | One-cycle pulse marking a new result |
| res | input | W | Conversion result, MSB at bit W-1 |
| dout | output | 1 | Shared ready/data pin |

## Verification
The bench builds the port with W=24, the full result width, and with short strobe windows (T_XFER=4, T_LOW=3, T_HIGH=2). This lets the strobe lengths be measured exactly on every transaction. T_DATA=300 leaves room for 30 serial clock periods of 8 system cycles each, so the over-read case past bit 24 can be reached alongside zero, partial and exact reads. A second result is injected in the middle of a data window, which exercises the holding path.

// File: rtl/rdy_dout_port.sv
module rdy_dout_port #(
  parameter int W      = 24,
  parameter int T_XFER = 4,
  parameter int T_LOW  = 3,
  parameter int T_HIGH = 2,
  parameter int T_DATA = 400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         res_vld,
  input  logic [W-1:0] res,
  output logic         dout
);

  localparam int TM1 = (T_XFER > T_LOW) ? T_XFER : T_LOW;
  localparam int TM2 = (T_HIGH > T_DATA) ? T_HIGH : T_DATA;
  localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
  localparam int CW = $clog2(TMAX + 1);

  typedef enum logic [2:0] {IDLE, XFER, LOWP, HIGHP, DATA} st_t;

  st_t           state;
  logic [CW-1:0] cnt, lim;
  logic [W-1:0]  sr, hold;
  logic          pend;
  logic          s1, s2, s3;
  logic          fall, last;

  assign fall = s3 & ~s2 & (state == DATA);
  assign last = (cnt == lim);
  assign dout = (state == LOWP) ? 1'b0 : (state == DATA) ? sr[W-1] : 1'b1;

  always_comb begin
    case (state)
      XFER:    lim = CW'(T_XFER - 1);
      LOWP:    lim = CW'(T_LOW - 1);
      HIGHP:   lim = CW'(T_HIGH - 1);
      DATA:    lim = CW'(T_DATA - 1);
      default: lim = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE;
      cnt   <= '0;
      sr    <= '0;
      hold  <= '0;
      pend  <= 1'b0;
      s1    <= 1'b0;
      s2    <= 1'b0;
      s3    <= 1'b0;
    end else begin
      s1 <= sclk;
      s2 <= s1;
      s3 <= s2;
      if (res_vld) begin
        hold <= res;
        pend <= 1'b1;
      end
      if (state == IDLE) begin
        if (pend) begin
          state <= XFER;
          cnt   <= '0;
          sr    <= hold;
          if (!res_vld) pend <= 1'b0;
        end
      end else begin
        if (fall) sr <= {sr[W-2:0], 1'b0};
        if (last) begin
          cnt <= '0;
          case (state)
            XFER:    state <= LOWP;
            LOWP:    state <= HIGHP;
            HIGHP:   state <= DATA;
            default: state <= IDLE;
          endcase
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R2
  strobe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == XFER && last) |=> !dout);

  // R7
  window_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == DATA && last) |=> dout);

  // R5
  hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == DATA && !fall && !last) |=> $stable(dout));

  // R8
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |=> pend);

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == IDLE && !pend) |=> dout);

endmodule

// File: tb/rdy_dout_port_bench.sv
module rdy_dout_port_bench;
  localparam int W = 24, TX = 4, TL = 3, TH = 2, TD = 300;

  typedef struct { logic [W-1:0] w; int n; } item_t;

  logic clk = 0, rst_n = 0, sclk = 0, res_vld = 0;
  logic [W-1:0] res = '0;
  logic dout;

  item_t q[$];
  int checks = 0, fails = 0, done_cnt = 0, dc = 0;
  bit ended = 0;

  rdy_dout_port #(.W(W), .T_XFER(TX), .T_LOW(TL), .T_HIGH(TH), .T_DATA(TD)) u_rdy_dout_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .res_vld(res_vld), .res(res), .dout(dout));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic adv();
    @(negedge clk);
    dc++;
  endtask

  task automatic send(input logic [W-1:0] w, input int n);
    item_t it;
    it.w = w;
    it.n = n;
    q.push_back(it);
    @(negedge clk);
    res = w;
    res_vld = 1;
    @(negedge clk);
    res_vld = 0;
  endtask

  // monitor: checks strobe, serial bits, hold value and return to ready mode
  initial begin
    item_t it;
    int lowc, highc;
    logic e;
    forever begin
      wait (q.size() > 0);
      it = q.pop_front();
      do @(negedge clk); while (dout !== 1'b0);
      lowc = 1;
      @(negedge clk);
      while (dout === 1'b0 && lowc < TL + 2) begin lowc++; @(negedge clk); end
      chk(lowc == TL, "R2 low strobe", lowc, TL);
      highc = 0;
      for (int i = 0; i < TH; i++) begin
        if (dout === 1'b1) highc++;
        @(negedge clk);
      end
      chk(highc == TH, "R2 high strobe", highc, TH);
      dc = 0;
      for (int i = 0; i < it.n; i++) begin
        e = (i < W) ? it.w[W-1-i] : 1'b0;
        chk(dout === e, (i == 0) ? "R3 msb first" : (i < W ? "R3 bit order" : "R6 over-read low"), dout, e);
        sclk = 1;
        repeat (4) adv();
        sclk = 0;
        repeat (4) adv();
      end
      e = (it.n < W) ? it.w[W-1-it.n] : 1'b0;
      chk(dout === e, (it.n == 0) ? "R4 no read holds msb" : (it.n < W ? "R5 partial hold" : "R6 low after read"), dout, e);
      while (dc < TD - 1) adv();
      chk(dout === e, "R5 held to window end", dout, e);
      adv();
      chk(dout === 1'b1, "R7 back to ready", dout, 1);
      done_cnt++;
    end
  end

  // driver
  initial begin
    int d;
    repeat (3) @(negedge clk);
    chk(dout === 1'b1, "R1 reset high", dout, 1);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(dout === 1'b1, "R1 idle high", dout, 1);
    d = done_cnt; send(24'hA5C3F1, 0);  wait (done_cnt == d + 1);
    d = done_cnt; send(24'h5A3C0E, 24); wait (done_cnt == d + 1);
    d = done_cnt; send(24'hF0F00F, 10); wait (done_cnt == d + 1);
    d = done_cnt; send(24'h123456, 30); wait (done_cnt == d + 1);
    d = done_cnt; send(24'h7FFFFE, 23); wait (done_cnt == d + 1);
    d = done_cnt; send(24'h800001, 1);  wait (done_cnt == d + 1);
    // R8: second result arrives during the first one's data window
    d = done_cnt;
    send(24'hC0FFEE, 5);
    repeat (40) @(negedge clk);
    send(24'h3B9ACA, 24);
    wait (done_cnt == d + 2);
    repeat (5) @(negedge clk);
    chk(dout === 1'b1, "R1 idle after all", dout, 1);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule